// File: doc/BRIEF.md
# Wrapper Boundary Chain with Silent Shift

This block is a chain of boundary cells that sits between a core and the rest of the chip. It covers N core input terminals and M core output terminals. Every cell holds two flops. The shift stage belongs to the serial scan path. The update stage feeds the cell's parallel output. Serial shifting therefore never disturbs what the core or the chip sees. The parallel side changes only when an update strobe copies the shift stages into the update stages.

An instruction controller drives four decoded mode selects. When none of them is asserted, the block runs in functional mode and passes every terminal straight through.
- **Outward mode** drives the core-output terminals from the update stages and samples the chip-side inputs.
- **Inward mode** drives the core inputs from the update stages and captures the core response. The chip-side outputs sit at a build-time safe level.
- **Clamp mode** freezes the update stages on both sides. The serial path shrinks to a single bypass flop.
- **Safe mode** forces build-time constants onto both parallel sides, whatever the update stages hold. It also routes the serial path through the bypass flop.

Top module: `bnd_chain`

## Requirements
- R1: A synchronous active-high reset clears every shift stage, every update stage and the bypass flop, so scan_out reads 0 after reset.
- R2: With no mode select asserted, core_in equals sys_in and sys_out equals core_out in the same cycle, with no register in the path.
- R3: In functional, outward and inward modes, the serial path runs from scan_in through input cells 0 to N-1, then output cells 0 to M-1, to scan_out. A bit presented on scan_in with shift_en high reaches scan_out after exactly N+M shift cycles.
- R4: Shifting changes no parallel output. During a shift, sys_out and core_in keep the values set by the last update.
- R5: When update_en is high in a chain mode, the clock edge copies every shift stage into its update stage. In outward mode, sys_out[j] shows output cell j's update value from the next cycle, independent of core_out.
- R6: In outward mode, capture_en loads input cell i with sys_in[i], and each output cell reloads its own update value.
- R7: In inward mode, core_in[i] is input cell i's update value and sys_out equals the SAFE_OUT parameter.
- R8: In inward mode, capture_en loads output cell j with core_out[j], and each input cell reloads its own update value, whatever sys_in holds. In functional mode, capture loads sys_in and core_out.
- R9: In clamp mode, both parallel sides come from the update stages. Shift, capture and update leave all cell stages unchanged. With shift_en high, scan_out shows the scan_in value from the previous shift cycle, through the bypass flop.
- R10: In safe mode, core_in equals SAFE_IN and sys_out equals SAFE_OUT. The serial path is the bypass flop, as in clamp mode, and no cell stage changes.
- R11: When several mode selects are high, priority runs safe, clamp, inward, outward.
- R12: If shift_en and capture_en are high on the same edge, the shift takes effect and the capture is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out: last output cell, or the bypass flop |
| shift_en | input | 1 | Shift the serial path one place |
| capture_en | input | 1 | Load the shift stages from the capture sources |
| update_en | input | 1 | Copy the shift stages into the update stages |
| sel_outward | input | 1 | Outward-facing test mode |
| sel_inward | input | 1 | Inward-facing test mode |
| sel_clamp | input | 1 | Hold outputs from the update stages, bypass path |
| sel_safe | input | 1 | Force build-time constants, bypass path |
| sys_in | input | N | Chip-side signals toward the core |
| core_in | output | N | Signals driven into the core |
| core_out | input | M | Core response signals |
| sys_out | output | M | Signals driven toward the chip |

## Verification
The bench goes after the following corner cases:

- **Silent shift.** A design that let the shift stages reach the pins would show sys_out moving during a load.
- **Chain order.** A design with input and output cells reversed would scramble the captured word read at scan_out.
- **Own-value recapture on input cells in inward mode.** A design that sampled sys_in there would leak the chip-side pattern into the scanned-out response.
- **Clamp and safe modes with update and capture strobes active.** A design that did not gate these strobes would alter the held outputs or the chain contents, which a later outward shift-out reveals.
- **Simultaneous mode selects and simultaneous shift and capture.** These catch a wrong priority order.

// File: rtl/bnd_pkg.sv
package bnd_pkg;
  typedef enum logic [2:0] {
    MD_FUNC    = 3'd0,
    MD_OUTWARD = 3'd1,
    MD_INWARD  = 3'd2,
    MD_CLAMP   = 3'd3,
    MD_SAFE    = 3'd4
  } bnd_mode_e;
endpackage

// File: rtl/bnd_mode_sel.sv
module bnd_mode_sel
  import bnd_pkg::*;
(
  input  logic      sel_outward,
  input  logic      sel_inward,
  input  logic      sel_clamp,
  input  logic      sel_safe,
  output bnd_mode_e mode,
  output logic      chain_act
);
  // Priority: safe, clamp, inward, outward, functional
  always_comb begin
    if (sel_safe)         mode = MD_SAFE;
    else if (sel_clamp)   mode = MD_CLAMP;
    else if (sel_inward)  mode = MD_INWARD;
    else if (sel_outward) mode = MD_OUTWARD;
    else                  mode = MD_FUNC;
  end

  assign chain_act = (mode != MD_SAFE) && (mode != MD_CLAMP);
endmodule

// File: rtl/bnd_cell.sv
module bnd_cell
  import bnd_pkg::*;
#(
  parameter bit IS_OUT = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  bnd_mode_e mode,
  input  logic      chain_act,
  input  logic      shift_en,
  input  logic      capture_en,
  input  logic      update_en,
  input  logic      ser_in,
  input  logic      func_in,
  input  logic      safe_val,
  output logic      par_out,
  output logic      sh_q,
  output logic      upd_q
);
  logic cap_own;
  logic force_safe;
  logic use_upd;
  logic cap_d;

  generate
    if (IS_OUT) begin : g_out
      assign cap_own    = (mode == MD_OUTWARD);
      assign force_safe = (mode == MD_SAFE) || (mode == MD_INWARD);
      assign use_upd    = (mode == MD_CLAMP) || (mode == MD_OUTWARD);
    end else begin : g_in
      assign cap_own    = (mode == MD_INWARD);
      assign force_safe = (mode == MD_SAFE);
      assign use_upd    = (mode == MD_CLAMP) || (mode == MD_INWARD);
    end
  endgenerate

  assign cap_d = cap_own ? upd_q : func_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= 1'b0;
      upd_q <= 1'b0;
    end else if (chain_act) begin
      if (shift_en)        sh_q <= ser_in;
      else if (capture_en) sh_q <= cap_d;
      if (update_en)       upd_q <= sh_q;
    end
  end

  assign par_out = force_safe ? safe_val : (use_upd ? upd_q : func_in);
endmodule

// File: rtl/bnd_bypass.sv
module bnd_bypass (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/bnd_chain.sv
module bnd_chain
  import bnd_pkg::*;
#(
  parameter int          N        = 8,
  parameter int          M        = 8,
  parameter logic [N-1:0] SAFE_IN  = '0,
  parameter logic [M-1:0] SAFE_OUT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scan_in,
  output logic         scan_out,
  input  logic         shift_en,
  input  logic         capture_en,
  input  logic         update_en,
  input  logic         sel_outward,
  input  logic         sel_inward,
  input  logic         sel_clamp,
  input  logic         sel_safe,
  input  logic [N-1:0] sys_in,
  output logic [N-1:0] core_in,
  input  logic [M-1:0] core_out,
  output logic [M-1:0] sys_out
);
  localparam int L = N + M;

  bnd_mode_e    mode;
  logic         chain_act;
  logic [L:0]   ser;
  logic [L-1:0] upd_vec;
  logic         byp_q;

  bnd_mode_sel u_mode (
    .sel_outward (sel_outward),
    .sel_inward  (sel_inward),
    .sel_clamp   (sel_clamp),
    .sel_safe    (sel_safe),
    .mode        (mode),
    .chain_act   (chain_act)
  );

  assign ser[0] = scan_in;

  generate
    for (genvar k = 0; k < L; k++) begin : g_cell
      if (k < N) begin : g_icell
        bnd_cell #(.IS_OUT(1'b0)) u_cell (
          .clk        (clk),
          .rst        (rst),
          .mode       (mode),
          .chain_act  (chain_act),
          .shift_en   (shift_en),
          .capture_en (capture_en),
          .update_en  (update_en),
          .ser_in     (ser[k]),
          .func_in    (sys_in[k]),
          .safe_val   (SAFE_IN[k]),
          .par_out    (core_in[k]),
          .sh_q       (ser[k+1]),
          .upd_q      (upd_vec[k])
        );
      end else begin : g_ocell
        bnd_cell #(.IS_OUT(1'b1)) u_cell (
          .clk        (clk),
          .rst        (rst),
          .mode       (mode),
          .chain_act  (chain_act),
          .shift_en   (shift_en),
          .capture_en (capture_en),
          .update_en  (update_en),
          .ser_in     (ser[k]),
          .func_in    (core_out[k-N]),
          .safe_val   (SAFE_OUT[k-N]),
          .par_out    (sys_out[k-N]),
          .sh_q       (ser[k+1]),
          .upd_q      (upd_vec[k])
        );
      end
    end
  endgenerate

  bnd_bypass u_byp (
    .clk (clk),
    .rst (rst),
    .en  (shift_en && !chain_act),
    .d   (scan_in),
    .q   (byp_q)
  );

  assign scan_out = chain_act ? ser[L] : byp_q;
endmodule

// File: rtl/bnd_chain_chk.sv
module bnd_chain_chk #(
  parameter int          N        = 8,
  parameter int          M        = 8,
  parameter logic [N-1:0] SAFE_IN  = '0,
  parameter logic [M-1:0] SAFE_OUT = '0
) (
  input logic           clk,
  input logic           rst,
  input logic           scan_in,
  input logic           scan_out,
  input logic           shift_en,
  input logic           update_en,
  input logic           sel_outward,
  input logic           sel_inward,
  input logic           sel_clamp,
  input logic           sel_safe,
  input logic [N-1:0]   sys_in,
  input logic [N-1:0]   core_in,
  input logic [M-1:0]   core_out,
  input logic [M-1:0]   sys_out,
  input logic [N+M-1:0] upd_vec
);
  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (rst)
    (!sel_outward && !sel_inward && !sel_clamp && !sel_safe) |-> (core_in == sys_in && sys_out == core_out)); // R2

  AST_SILENT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !update_en |=> $stable(upd_vec)); // R4

  AST_INWARD_SAFE: assert property (@(posedge clk) disable iff (rst)
    (sel_inward && !sel_clamp && !sel_safe) |-> (sys_out == SAFE_OUT)); // R7

  AST_CLAMP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (sel_clamp || sel_safe) |=> $stable(upd_vec)); // R9

  AST_BYPASS_BIT: assert property (@(posedge clk) disable iff (rst)
    (shift_en && (sel_clamp || sel_safe)) |=> (!(sel_clamp || sel_safe) || scan_out == $past(scan_in))); // R9

  AST_SAFE_FORCE: assert property (@(posedge clk) disable iff (rst)
    sel_safe |-> (core_in == SAFE_IN && sys_out == SAFE_OUT)); // R10
endmodule

bind bnd_chain bnd_chain_chk #(
  .N(N), .M(M), .SAFE_IN(SAFE_IN), .SAFE_OUT(SAFE_OUT)
) u_chk (
  .clk(clk), .rst(rst), .scan_in(scan_in), .scan_out(scan_out),
  .shift_en(shift_en), .update_en(update_en),
  .sel_outward(sel_outward), .sel_inward(sel_inward),
  .sel_clamp(sel_clamp), .sel_safe(sel_safe),
  .sys_in(sys_in), .core_in(core_in), .core_out(core_out),
  .sys_out(sys_out), .upd_vec(upd_vec)
);

// File: tb/bnd_chain_bench.sv
module bnd_chain_bench;
  localparam int N = 5;
  localparam int M = 4;
  localparam int L = N + M;
  localparam logic [N-1:0] S_IN  = 5'b10011;
  localparam logic [M-1:0] S_OUT = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic sel_outward = 1'b0, sel_inward = 1'b0, sel_clamp = 1'b0, sel_safe = 1'b0;
  logic [N-1:0] sys_in = 5'h15;
  logic [M-1:0] core_out = 4'h9;
  logic         scan_out;
  logic [N-1:0] core_in;
  logic [M-1:0] sys_out;

  always #4 clk = ~clk;

  bnd_chain #(.N(N), .M(M), .SAFE_IN(S_IN), .SAFE_OUT(S_OUT)) u_bnd_chain (
    .clk(clk), .rst(rst), .scan_in(scan_in), .scan_out(scan_out),
    .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
    .sel_outward(sel_outward), .sel_inward(sel_inward),
    .sel_clamp(sel_clamp), .sel_safe(sel_safe),
    .sys_in(sys_in), .core_in(core_in), .core_out(core_out), .sys_out(sys_out)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the chain, built from the requirements
  logic [L-1:0] m_sh = '0;
  logic [L-1:0] m_upd = '0;
  logic         m_byp = 1'b0;

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? {15'd0, scan_out} :
            (it.sel == 1) ? {11'd0, core_in} : {12'd0, sys_out};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h t=%0t", it.tag, it.sel, act, it.exp, $time);
      end
    end
  end

  function automatic int md();
    if (sel_safe) return 4;
    if (sel_clamp) return 3;
    if (sel_inward) return 2;
    if (sel_outward) return 1;
    return 0;
  endfunction

  function automatic logic [N-1:0] e_core_in(int m);
    if (m == 4) return S_IN;
    if (m == 3 || m == 2) return m_upd[N-1:0];
    return sys_in;
  endfunction

  function automatic logic [M-1:0] e_sys_out(int m);
    if (m == 4 || m == 2) return S_OUT;
    if (m == 3 || m == 1) return m_upd[L-1:N];
    return core_out;
  endfunction

  function automatic void push(string tag, int sel, logic [15:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    q.push_back(it);
  endfunction

  task automatic step(input logic sh, input logic cap, input logic up, input logic sin, input string tag);
    int m;
    logic chain;
    logic [L-1:0] capv;
    logic [L-1:0] old_sh;
    m = md();
    chain = (m < 3);
    push(tag, 0, {15'd0, chain ? m_sh[L-1] : m_byp});
    push(tag, 1, {11'd0, e_core_in(m)});
    push(tag, 2, {12'd0, e_sys_out(m)});
    shift_en = sh; capture_en = cap; update_en = up; scan_in = sin;
    for (int k = 0; k < L; k++) begin
      if (k < N) capv[k] = (m == 2) ? m_upd[k] : sys_in[k];
      else       capv[k] = (m == 1) ? m_upd[k] : core_out[k-N];
    end
    old_sh = m_sh;
    @(posedge clk); #1;
    if (chain) begin
      if (sh)       m_sh = {old_sh[L-2:0], sin};
      else if (cap) m_sh = capv;
      if (up)       m_upd = old_sh;
    end else if (sh) begin
      m_byp = sin;
    end
    shift_en = 1'b0; capture_en = 1'b0; update_en = 1'b0;
  endtask

  task automatic load(input logic [L-1:0] v, input string tag);
    for (int t = 0; t < L; t++) step(1'b1, 1'b0, 1'b0, v[L-1-t], tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    step(0, 0, 0, 0, "R1");
    // functional pass-through
    sys_in = 5'h0A; core_out = 4'h6; step(0, 0, 0, 0, "R2");
    sys_in = 5'h1F; core_out = 4'h0; step(0, 0, 0, 0, "R2");
    // outward: silent load, then update
    sel_outward = 1'b1;
    load(9'h1A5, "R4");
    step(0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, "R5");
    core_out = 4'hF; step(0, 0, 0, 0, "R5");
    // outward capture and readout
    sys_in = 5'h0B; step(0, 1, 0, 0, "R6");
    load(9'h0C3, "R6");
    load(9'h000, "R3");
    load(9'h13C, "R3");
    step(0, 0, 1, 0, "R5");
    // inward
    sel_outward = 1'b0; sel_inward = 1'b1;
    sys_in = 5'h04; core_out = 4'hA;
    step(0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, "R8");
    load(9'h055, "R8");
    step(0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, "R7");
    // shift wins over capture
    step(1, 1, 0, 1, "R12");
    step(0, 0, 0, 0, "R12");
    // functional capture
    sel_inward = 1'b0; sys_in = 5'h12; core_out = 4'h5;
    step(0, 1, 0, 0, "R8");
    load(9'h000, "R8");
    // clamp
    sel_clamp = 1'b1;
    step(1, 1, 1, 1, "R9");
    step(1, 0, 1, 0, "R9");
    step(1, 0, 0, 1, "R9");
    sys_in = 5'h1C; core_out = 4'h3;
    step(0, 1, 1, 0, "R9");
    step(0, 0, 0, 0, "R9");
    sel_clamp = 1'b0; sel_outward = 1'b1;
    load(9'h1FF, "R9");
    // safe (outward also high)
    sel_safe = 1'b1;
    step(1, 0, 1, 1, "R10");
    step(1, 1, 1, 0, "R10");
    sys_in = 5'h07; step(0, 0, 0, 0, "R10");
    sel_safe = 1'b0;
    step(0, 0, 0, 0, "R10");
    // priority among mode selects
    sel_safe = 1'b1; sel_clamp = 1'b1; sel_inward = 1'b1; step(0, 0, 0, 0, "R11");
    sel_safe = 1'b0; step(1, 0, 0, 1, "R11");
    sel_clamp = 1'b0; step(0, 0, 0, 0, "R11");
    sel_inward = 1'b0; sel_outward = 1'b0;
    sys_in = 5'h19; core_out = 4'hC; step(0, 0, 0, 0, "R2");
    @(negedge clk); #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule